// File: doc/BRIEF.md
# Vectored Interrupt Controller Register Bank

This block gathers 64 level-sensitive interrupt sources behind a small 32-bit register bus. Software can turn each source on or off, either by writing its number to a set or a clear register or by writing whole enable words. Each source can be steered to a normal or a fast request output and given a 4-bit priority. A software force word can raise any source as if its input were high.

Two arbiters run in parallel, one for each output class. Each one picks the highest-priority pending source, and ties go to the higher source number. The result is published as a vector word: the source number in the upper half and its priority in the lower half, or all ones when nothing qualifies. The normal path also applies a priority threshold. A request output is high while its vector names a source.

Bus accesses are single-cycle strobes. A write takes effect at the clock edge that samples it. Read data is registered and is valid after the edge that samples the read.

Top module: `vic_regbank`

## Requirements
- R1: After reset, these registers read as follows: control 0, normal threshold 0x1F, all enable, type, force and priority words 0. Both vector words read 0xFFFF_FFFF, and both request outputs are low.
- R2: Writing a value N below 64 to the set-number register (0x08) sets enable bit N. Writing N to the clear-number register (0x0C) clears enable bit N. No other enable bit changes. A value of 64 or more written to either register changes nothing.
- R3: The enable (0x10 high, 0x14 low), type (0x18/0x1C), force (0x50/0x54) and control (0x00) words read back what was last written. A high word holds sources 32–63 with bit k mapped to source 32+k. A low word holds sources 0–31.
- R4: Source N's 4-bit priority sits at bits [4*(N%8)+3 : 4*(N%8)] of the priority word at offset 0x20 + 4*(7 - N/8). The word at 0x20 covers sources 56–63 and the word at 0x3C covers sources 0–7.
- R5: The source words (0x48 high, 0x4C low) read the OR of the sampled input lines and the force word.
- R6: The normal pending words (0x58/0x5C) read source AND enable AND NOT type. The fast pending words (0x60/0x64) read source AND enable AND type. Type 1 means fast.
- R7: The normal vector word (0x40) holds the source number in [31:16] and its priority in [15:0]. It names the highest-priority presented normal source, with ties going to the higher number, or it reads 0xFFFF_FFFF when none is presented. The normal request output is high exactly when a source is named.
- R8: A pending normal source is presented only if the threshold (0x04, 5 bits) equals 0x1F or the source's priority is greater than the threshold.
- R9: The fast vector word (0x44) and the fast request output follow R7, using the fast pending sources and no threshold.
- R10: A change on the source inputs reaches the request outputs after the second rising edge. A register write reaches them at the rising edge after the write edge.
- R11: Writes to the read-only words (source, pending and vector words) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address (bits [1:0] ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| src_in | input | 64 | Level-sensitive interrupt lines |
| nirq | output | 1 | Normal interrupt request |
| firq | output | 1 | Fast interrupt request |

## Verification
On every cycle, the assertions check three things about the number registers and the arbiters. A set-number or clear-number write touches at most the one enable bit it names, and an out-of-range number leaves the enable words untouched. A vector that names a source has a legal number and a clean priority field. The fast request follows the previous cycle's fast pending set, and any presented normal source beats the threshold that was in force. Only the bench scenarios can show the parts of the behaviour that depend on the address map and on comparison across sources. These are the reversed priority word layout, the tie-break toward the higher number, force merging, type routing, the exact vector values, and the latency in cycles of writes and input changes.

// File: rtl/vic_pkg.sv
package vic_pkg;
  // Word index (byte address / 4) of each register
  localparam logic [4:0] W_CTRL   = 5'd0;
  localparam logic [4:0] W_MASK   = 5'd1;
  localparam logic [4:0] W_ENNUM  = 5'd2;
  localparam logic [4:0] W_DISNUM = 5'd3;
  localparam logic [4:0] W_ENH    = 5'd4;
  localparam logic [4:0] W_ENL    = 5'd5;
  localparam logic [4:0] W_TYPH   = 5'd6;
  localparam logic [4:0] W_TYPL   = 5'd7;
  localparam logic [4:0] W_PRIO0  = 5'd8;   // first of eight priority words
  localparam logic [4:0] W_NVEC   = 5'd16;
  localparam logic [4:0] W_FVEC   = 5'd17;
  localparam logic [4:0] W_SRCH   = 5'd18;
  localparam logic [4:0] W_SRCL   = 5'd19;
  localparam logic [4:0] W_FRCH   = 5'd20;
  localparam logic [4:0] W_FRCL   = 5'd21;
  localparam logic [4:0] W_NPH    = 5'd22;
  localparam logic [4:0] W_NPL    = 5'd23;
  localparam logic [4:0] W_FPH    = 5'd24;
  localparam logic [4:0] W_FPL    = 5'd25;
endpackage

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int DATA_W  = 32,
  parameter int PRIO_W  = 4,
  parameter int MASK_W  = 5,
  parameter int WIDX_W  = 5
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [WIDX_W-1:0]         wr_idx,
  input  logic [DATA_W-1:0]         wr_data,
  output logic [DATA_W-1:0]         ctrl_q,
  output logic [MASK_W-1:0]         mask_q,
  output logic [NUM_SRC-1:0]        en_q,
  output logic [NUM_SRC-1:0]        typ_q,
  output logic [NUM_SRC-1:0]        frc_q,
  output logic [NUM_SRC*PRIO_W-1:0] prio_q
);
  localparam int SRC_W    = $clog2(NUM_SRC);
  localparam int HALF     = DATA_W;
  localparam int PER_WORD = DATA_W / PRIO_W;
  localparam int GROUPS   = NUM_SRC / PER_WORD;

  logic             num_ok;
  logic [SRC_W-1:0] num;

  assign num_ok = (wr_data < DATA_W'(NUM_SRC));
  assign num    = wr_data[SRC_W-1:0];

  // Control and threshold
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      mask_q <= '1;
    end else if (wr_en) begin
      if (wr_idx == W_CTRL) ctrl_q <= wr_data;
      if (wr_idx == W_MASK) mask_q <= wr_data[MASK_W-1:0];
    end
  end

  // Enable: by number or by whole word
  always_ff @(posedge clk) begin
    if (rst) begin
      en_q <= '0;
    end else if (wr_en) begin
      case (wr_idx)
        W_ENNUM:  if (num_ok) en_q[num] <= 1'b1;
        W_DISNUM: if (num_ok) en_q[num] <= 1'b0;
        W_ENH:    en_q[NUM_SRC-1:HALF] <= wr_data;
        W_ENL:    en_q[HALF-1:0]       <= wr_data;
        default:  ;
      endcase
    end
  end

  // Type and force words
  always_ff @(posedge clk) begin
    if (rst) begin
      typ_q <= '0;
      frc_q <= '0;
    end else if (wr_en) begin
      case (wr_idx)
        W_TYPH:  typ_q[NUM_SRC-1:HALF] <= wr_data;
        W_TYPL:  typ_q[HALF-1:0]       <= wr_data;
        W_FRCH:  frc_q[NUM_SRC-1:HALF] <= wr_data;
        W_FRCL:  frc_q[HALF-1:0]       <= wr_data;
        default: ;
      endcase
    end
  end

  // Priority words: group g lives in slot (GROUPS-1-g)
  for (genvar g = 0; g < GROUPS; g++) begin : g_prio
    localparam logic [WIDX_W-1:0] SLOT = WIDX_W'(int'(W_PRIO0) + (GROUPS - 1 - g));
    logic [DATA_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (rst)                          word_q <= '0;
      else if (wr_en && wr_idx == SLOT) word_q <= wr_data;
    end
    assign prio_q[g*DATA_W +: DATA_W] = word_q;
  end

  AST_ENNUM_SETS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == W_ENNUM && num_ok) |=> en_q[$past(num)]); // R2
  AST_DISNUM_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == W_DISNUM && num_ok) |=> !en_q[$past(num)]); // R2
  AST_NUM_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_idx == W_ENNUM || wr_idx == W_DISNUM)) |=> ($countones(en_q ^ $past(en_q)) <= 1)); // R2
  AST_NUM_RANGE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_idx == W_ENNUM || wr_idx == W_DISNUM) && !num_ok) |=> $stable(en_q)); // R2
endmodule

// File: rtl/vic_arb.sv
module vic_arb #(
  parameter int NUM_SRC  = 64,
  parameter int DATA_W   = 32,
  parameter int PRIO_W   = 4,
  parameter int MASK_W   = 5,
  parameter bit USE_MASK = 1'b1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_SRC-1:0]        pend,
  input  logic [NUM_SRC*PRIO_W-1:0] prio,
  input  logic [MASK_W-1:0]         mask,
  output logic                      req_q,
  output logic [DATA_W-1:0]         vec_q
);
  localparam int SRC_W  = $clog2(NUM_SRC);
  localparam int HALF_W = DATA_W / 2;

  logic [NUM_SRC-1:0] qual;
  logic               found;
  logic [PRIO_W-1:0]  best;
  logic [SRC_W-1:0]   idx;

  if (USE_MASK) begin : g_mask
    logic open;
    assign open = (mask == '1);
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_q
      assign qual[i] = pend[i] && (open || (MASK_W'(prio[i*PRIO_W +: PRIO_W]) > mask));
    end
  end else begin : g_nomask
    assign qual = pend;
  end

  // Scan upward; >= lets the higher number win a tie
  always_comb begin
    found = 1'b0;
    best  = '0;
    idx   = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (qual[i] && (!found || prio[i*PRIO_W +: PRIO_W] >= best)) begin
        found = 1'b1;
        best  = prio[i*PRIO_W +: PRIO_W];
        idx   = SRC_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      vec_q <= '1;
    end else begin
      req_q <= found;
      vec_q <= found ? {HALF_W'(idx), HALF_W'(best)} : '1;
    end
  end

  AST_VEC_WELL_FORMED: assert property (@(posedge clk) disable iff (rst)
    req_q |-> (vec_q[DATA_W-1:HALF_W] < HALF_W'(NUM_SRC) && vec_q[HALF_W-1:PRIO_W] == '0)); // R7

  if (USE_MASK) begin : g_ast_mask
    AST_THRESHOLD_RESPECTED: assert property (@(posedge clk) disable iff (rst)
      req_q |-> ($past(mask) == '1 || MASK_W'(vec_q[PRIO_W-1:0]) > $past(mask))); // R8
  end else begin : g_ast_fast
    AST_FAST_REQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
      1'b1 |-> (req_q == $past(|pend))); // R9
  end
endmodule

// File: rtl/vic_regbank.sv
module vic_regbank
  import vic_pkg::*;
#(
  parameter int NUM_SRC = 64,
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 7,
  parameter int PRIO_W  = 4,
  parameter int MASK_W  = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] src_in,
  output logic               nirq,
  output logic               firq
);
  localparam int WIDX_W = ADDR_W - 2;
  localparam int HALF   = DATA_W;
  localparam int PER_WORD = DATA_W / PRIO_W;
  localparam int GROUPS = NUM_SRC / PER_WORD;

  logic                      wr_en;
  logic [WIDX_W-1:0]         widx;
  logic [DATA_W-1:0]         ctrl_q;
  logic [MASK_W-1:0]         mask_q;
  logic [NUM_SRC-1:0]        en_q, typ_q, frc_q;
  logic [NUM_SRC*PRIO_W-1:0] prio_q;
  logic [NUM_SRC-1:0]        src_q, raw, npend, fpend;
  logic [DATA_W-1:0]         nvec, fvec, rd_word;

  assign wr_en = bus_sel && bus_wr;
  assign widx  = bus_addr[ADDR_W-1:2];

  vic_regs #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .PRIO_W(PRIO_W),
    .MASK_W(MASK_W), .WIDX_W(WIDX_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(widx), .wr_data(bus_wdata),
    .ctrl_q(ctrl_q), .mask_q(mask_q), .en_q(en_q), .typ_q(typ_q),
    .frc_q(frc_q), .prio_q(prio_q)
  );

  always_ff @(posedge clk) begin
    if (rst) src_q <= '0;
    else     src_q <= src_in;
  end

  assign raw   = src_q | frc_q;
  assign npend = raw & en_q & ~typ_q;
  assign fpend = raw & en_q & typ_q;

  vic_arb #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .PRIO_W(PRIO_W),
    .MASK_W(MASK_W), .USE_MASK(1'b1)
  ) u_narb (
    .clk(clk), .rst(rst), .pend(npend), .prio(prio_q), .mask(mask_q),
    .req_q(nirq), .vec_q(nvec)
  );

  vic_arb #(
    .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .PRIO_W(PRIO_W),
    .MASK_W(MASK_W), .USE_MASK(1'b0)
  ) u_farb (
    .clk(clk), .rst(rst), .pend(fpend), .prio(prio_q), .mask(mask_q),
    .req_q(firq), .vec_q(fvec)
  );

  always_comb begin
    rd_word = '0;
    case (widx)
      W_CTRL:  rd_word = ctrl_q;
      W_MASK:  rd_word = DATA_W'(mask_q);
      W_ENH:   rd_word = en_q[NUM_SRC-1:HALF];
      W_ENL:   rd_word = en_q[HALF-1:0];
      W_TYPH:  rd_word = typ_q[NUM_SRC-1:HALF];
      W_TYPL:  rd_word = typ_q[HALF-1:0];
      W_NVEC:  rd_word = nvec;
      W_FVEC:  rd_word = fvec;
      W_SRCH:  rd_word = raw[NUM_SRC-1:HALF];
      W_SRCL:  rd_word = raw[HALF-1:0];
      W_FRCH:  rd_word = frc_q[NUM_SRC-1:HALF];
      W_FRCL:  rd_word = frc_q[HALF-1:0];
      W_NPH:   rd_word = npend[NUM_SRC-1:HALF];
      W_NPL:   rd_word = npend[HALF-1:0];
      W_FPH:   rd_word = fpend[NUM_SRC-1:HALF];
      W_FPL:   rd_word = fpend[HALF-1:0];
      default: begin
        for (int g = 0; g < GROUPS; g++) begin
          if (widx == WIDX_W'(int'(W_PRIO0) + (GROUPS - 1 - g)))
            rd_word = prio_q[g*DATA_W +: DATA_W];
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                      bus_rdata <= '0;
    else if (bus_sel && !bus_wr)  bus_rdata <= rd_word;
  end

  AST_NIRQ_NEEDS_PENDING: assert property (@(posedge clk) disable iff (rst)
    nirq |-> $past(|npend)); // R7
endmodule

// File: tb/vic_regbank_bench.sv
`timescale 1ns/1ps
module vic_regbank_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] src_in = '0;
  logic        nirq, firq;

  always #10 clk = ~clk;

  vic_regbank u_vic_regbank (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .src_in(src_in), .nirq(nirq), .firq(firq)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // Reference model
  logic [31:0] m_ctrl;
  logic [4:0]  m_mask;
  logic [63:0] m_en, m_typ, m_frc, m_src;
  logic [31:0] m_prio [8];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic void model_write(logic [6:0] a, logic [31:0] d);
    case (a)
      7'h00: m_ctrl = d;
      7'h04: m_mask = d[4:0];
      7'h08: if (d < 64) m_en[d[5:0]] = 1'b1;
      7'h0C: if (d < 64) m_en[d[5:0]] = 1'b0;
      7'h10: m_en[63:32]  = d;
      7'h14: m_en[31:0]   = d;
      7'h18: m_typ[63:32] = d;
      7'h1C: m_typ[31:0]  = d;
      7'h50: m_frc[63:32] = d;
      7'h54: m_frc[31:0]  = d;
      default: if (a >= 7'h20 && a <= 7'h3C) m_prio[7 - ((int'(a) - 32) / 4)] = d;
    endcase
  endfunction

  function automatic logic [31:0] exp_vec(bit fast);
    logic [63:0] raw;
    logic [3:0]  p, best;
    int          idx;
    bit          found, ok;
    raw = m_src | m_frc;
    found = 0; best = 0; idx = 0;
    for (int i = 0; i < 64; i++) begin
      p  = m_prio[i/8][4*(i%8) +: 4];
      ok = raw[i] && m_en[i] && (m_typ[i] == fast) &&
           (fast || m_mask == 5'h1F || {1'b0, p} > m_mask);
      if (ok && (!found || p >= best)) begin
        found = 1; best = p; idx = i;
      end
    end
    return found ? {16'(idx), 12'd0, best} : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [31:0] exp_read(logic [6:0] a);
    logic [63:0] raw, np, fp;
    raw = m_src | m_frc;
    np = raw & m_en & ~m_typ;
    fp = raw & m_en & m_typ;
    case (a)
      7'h00: return m_ctrl;
      7'h04: return {27'd0, m_mask};
      7'h10: return m_en[63:32];
      7'h14: return m_en[31:0];
      7'h18: return m_typ[63:32];
      7'h1C: return m_typ[31:0];
      7'h40: return exp_vec(0);
      7'h44: return exp_vec(1);
      7'h48: return raw[63:32];
      7'h4C: return raw[31:0];
      7'h50: return m_frc[63:32];
      7'h54: return m_frc[31:0];
      7'h58: return np[63:32];
      7'h5C: return np[31:0];
      7'h60: return fp[63:32];
      7'h64: return fp[31:0];
      default: begin
        if (a >= 7'h20 && a <= 7'h3C) return m_prio[7 - ((int'(a) - 32) / 4)];
        return 32'd0;
      end
    endcase
  endfunction

  task automatic bwrite(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    model_write(a, d);
  endtask

  task automatic bread(logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    d = bus_rdata;
  endtask

  task automatic rchk(string tag, logic [6:0] a, logic [31:0] exp);
    logic [31:0] d;
    bread(a, d);
    chk(tag, d, exp);
  endtask

  task automatic set_src(logic [63:0] v);
    @(negedge clk);
    src_in = v; m_src = v;
    repeat (2) @(negedge clk);
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, r;
    logic [6:0]  ra;
    logic [6:0]  rd_list [16];
    r = $urandom(32'd4321);
    rd_list = '{7'h00, 7'h04, 7'h10, 7'h14, 7'h18, 7'h1C, 7'h20, 7'h2C,
                7'h3C, 7'h48, 7'h4C, 7'h50, 7'h58, 7'h5C, 7'h60, 7'h64};
    m_ctrl = 0; m_mask = 5'h1F; m_en = 0; m_typ = 0; m_frc = 0; m_src = 0;
    for (int g = 0; g < 8; g++) m_prio[g] = 0;
    repeat (3) @(negedge clk);
    rst = 0;

    // R1 reset state
    rchk("R1 ctrl", 7'h00, 32'd0);
    rchk("R1 mask", 7'h04, 32'h1F);
    rchk("R1 enable low", 7'h14, 32'd0);
    rchk("R1 type high", 7'h18, 32'd0);
    rchk("R1 prio 0x3C", 7'h3C, 32'd0);
    rchk("R1 nvec", 7'h40, 32'hFFFF_FFFF);
    rchk("R1 fvec", 7'h44, 32'hFFFF_FFFF);
    chk("R1 nirq/firq", {30'd0, nirq, firq}, 32'd0);

    // R2 enable/disable by number
    bwrite(7'h08, 32'd5);
    rchk("R2 set 5", 7'h14, 32'h0000_0020);
    bwrite(7'h08, 32'd40);
    rchk("R2 set 40", 7'h10, 32'h0000_0100);
    bwrite(7'h08, 32'd64);
    bwrite(7'h0C, 32'hFFFF_FFFF);
    rchk("R2 out of range high", 7'h10, 32'h0000_0100);
    rchk("R2 out of range low", 7'h14, 32'h0000_0020);
    bwrite(7'h0C, 32'd5);
    rchk("R2 clear 5", 7'h14, 32'd0);
    rchk("R2 40 kept", 7'h10, 32'h0000_0100);

    // R3 readback
    bwrite(7'h00, 32'hDEAD_BEEF);
    rchk("R3 ctrl", 7'h00, 32'hDEAD_BEEF);
    bwrite(7'h18, 32'h8000_0001);
    rchk("R3 type high", 7'h18, 32'h8000_0001);
    bwrite(7'h18, 32'd0);

    // R4 priority layout, R7 vector
    bwrite(7'h20, 32'h0000_000F);   // source 56 -> 0xF
    bwrite(7'h3C, 32'hA000_0000);   // source 7  -> 0xA
    rchk("R4 prio 0x20", 7'h20, 32'h0000_000F);
    bwrite(7'h0C, 32'd40);
    bwrite(7'h08, 32'd56);
    bwrite(7'h08, 32'd7);
    set_src(64'h0100_0000_0000_0080);
    rchk("R7 highest prio wins", 7'h40, 32'h0038_000F);
    chk("R7 nirq high", {31'd0, nirq}, 32'd1);
    bwrite(7'h20, 32'd0);
    bwrite(7'h3C, 32'd0);
    rchk("R7 tie to higher number", 7'h40, 32'h0038_0000);

    // R8 threshold
    bwrite(7'h20, 32'h0000_000F);
    bwrite(7'h3C, 32'hA000_0000);
    bwrite(7'h04, 32'hA);
    rchk("R8 mask A passes F only", 7'h40, 32'h0038_000F);
    bwrite(7'h04, 32'hF);
    rchk("R8 mask F blocks all", 7'h40, 32'hFFFF_FFFF);
    chk("R8 nirq low", {31'd0, nirq}, 32'd0);
    bwrite(7'h0C, 32'd56);
    bwrite(7'h04, 32'h9);
    rchk("R8 mask 9 passes A", 7'h40, 32'h0007_000A);
    bwrite(7'h04, 32'h1E);
    rchk("R8 mask 1E blocks", 7'h40, 32'hFFFF_FFFF);

    // R10 write latency: threshold opened
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 7'h04; bus_wdata = 32'h1F;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; model_write(7'h04, 32'h1F);
    chk("R10 nirq not yet after write edge", {31'd0, nirq}, 32'd0);
    @(negedge clk);
    chk("R10 nirq one edge after write", {31'd0, nirq}, 32'd1);

    // R10 input latency
    @(negedge clk); src_in = 64'd0; m_src = 64'd0;
    @(negedge clk);
    chk("R10 nirq held after first edge", {31'd0, nirq}, 32'd1);
    @(negedge clk);
    chk("R10 nirq drops after second edge", {31'd0, nirq}, 32'd0);

    // R9 fast path, R6 pending
    bwrite(7'h1C, 32'h0000_0080);
    set_src(64'h0000_0000_0000_0080);
    rchk("R9 fast vector", 7'h44, 32'h0007_000A);
    chk("R9 firq", {30'd0, nirq, firq}, 32'd1);
    rchk("R6 fast pending low", 7'h64, 32'h0000_0080);
    rchk("R6 normal pending low", 7'h5C, 32'd0);
    rchk("R9 normal vec empty", 7'h40, 32'hFFFF_FFFF);

    // R5 force
    set_src(64'd0);
    bwrite(7'h08, 32'd3);
    bwrite(7'h54, 32'h0000_0008);
    rchk("R5 source from force", 7'h4C, 32'h0000_0008);
    rchk("R6 forced pending", 7'h5C, 32'h0000_0008);
    rchk("R5 forced vector", 7'h40, 32'h0003_0000);

    // R11 read-only writes
    bwrite(7'h58, 32'hFFFF_FFFF);
    bwrite(7'h40, 32'h0);
    bwrite(7'h4C, 32'hFFFF_FFFF);
    rchk("R11 pending unchanged", 7'h5C, 32'h0000_0008);
    rchk("R11 vector unchanged", 7'h40, 32'h0003_0000);
    rchk("R11 source unchanged", 7'h4C, 32'h0000_0008);

    // Random mix, checked against the model
    for (int it = 0; it < 400; it++) begin
      case ($urandom_range(0, 8))
        0: bwrite(7'h08, $urandom_range(0, 70));
        1: bwrite(7'h0C, $urandom_range(0, 70));
        2: bwrite(7'(7'h20 + 4 * $urandom_range(0, 7)), $urandom);
        3: bwrite(7'h04, ($urandom_range(0, 1) == 1) ? 32'h1F : $urandom_range(0, 20));
        4: bwrite($urandom_range(0, 1) ? 7'h18 : 7'h1C, $urandom & $urandom);
        5: bwrite($urandom_range(0, 1) ? 7'h50 : 7'h54, $urandom & $urandom & $urandom);
        6: begin
             @(negedge clk);
             src_in = {$urandom & $urandom, $urandom & $urandom};
             m_src = src_in;
           end
        7: bwrite($urandom_range(0, 1) ? 7'h10 : 7'h14, $urandom);
        default: bwrite(7'h00, $urandom);
      endcase
      repeat (2) @(negedge clk);
      rchk("R7 random normal vector", 7'h40, exp_vec(0));
      rchk("R9 random fast vector", 7'h44, exp_vec(1));
      ra = rd_list[$urandom_range(0, 15)];
      bread(ra, d);
      chk($sformatf("R6 random read %h", ra), d, exp_read(ra));
      chk("R8 random nirq", {31'd0, nirq}, {31'd0, exp_vec(0) != 32'hFFFF_FFFF});
      chk("R9 random firq", {31'd0, firq}, {31'd0, exp_vec(1) != 32'hFFFF_FFFF});
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule